// File: doc/BRIEF.md
# UART Interrupt Cause Resolver

This block merges the interrupt sources of a serial port (receive line errors, receive data at the trigger level, a stalled receive FIFO, an empty transmit holding register and two automatic baud-rate detection events) into one interrupt request line. It also produces a 10-bit identification word that tells software which cause is being served. The pending flag in that word is active low. Below it sits a 3-bit cause code that is chosen by fixed priority. Higher bits report whether the FIFOs are on and the state of the two auto-baud events.

The block keeps a small amount of state. A character-time counter detects a receive FIFO that holds data but has seen no traffic for a set number of character times. A latch records a fresh transmit-empty event. That event is dropped when software reads the identification word while the transmit-empty cause is the one shown, so one read acknowledges it. The surrounding receiver, FIFO and transmitter supply live status levels and single-cycle strobes.

Top module: `uirq_ident`

## Requirements
- R1: After reset, with all sources idle and FIFOs off, `irq` is 0 and `id_word` equals 10'h001.
- R2: `id_word[0]` is 0 exactly when an enabled cause is pending, and `irq` is its inverse. When nothing is pending the cause code `id_word[3:1]` is 000.
- R3: With enable bit 2 set, any one of overrun, parity, framing or break gives cause code 011. This outranks every other cause.
- R4: With enable bit 0 set, a receive level at or above the trigger gives code 010, which outranks transmit-empty. The trigger selects map 00→1, 01→4, 10→8 and 11→14 characters. With FIFOs off the trigger is 1.
- R5: With enable bit 0 set, FIFOs on and a non-empty receive FIFO, 4 character ticks with no push and no pop give code 110. The code appears in the cycle after the 4th tick. A push or pop restarts the count, including one that comes in the same cycle as a tick. Code 010 wins over 110.
- R6: With enable bit 1 set, a rise of `thr_empty` marks the transmit-empty cause from the next cycle on, with code 001. This cause has the lowest code priority.
- R7: A read strobe while code 001 is shown and pending clears the transmit-empty cause until `thr_empty` falls and rises again. A read while a different code is shown leaves it pending.
- R8: `id_word[7:6]` both equal `fifo_on`. Bit 8 is auto-baud end gated by enable bit 4, and bit 9 is auto-baud timeout gated by enable bit 3. Either one alone makes the word pending with code 000.
- R9: A source whose enable bit is clear has no effect on `irq`, the pending bit, the code or bits 9:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ien | input | 5 | Enables: 0 rx data, 1 tx empty, 2 line status, 3 auto-baud timeout, 4 auto-baud end |
| fifo_on | input | 1 | FIFOs enabled |
| trig_sel | input | 2 | Receive trigger level select |
| rx_level | input | LVL_W | Characters held in the receive FIFO |
| rx_push | input | 1 | Strobe: character written into the receive FIFO |
| rx_pop | input | 1 | Strobe: character read from the receive FIFO |
| char_tick | input | 1 | Strobe: one character time elapsed |
| err_overrun | input | 1 | Overrun flag |
| err_parity | input | 1 | Parity error flag |
| err_frame | input | 1 | Framing error flag |
| err_break | input | 1 | Break flag |
| thr_empty | input | 1 | Transmit holding register empty |
| ab_end | input | 1 | Auto-baud completed |
| ab_tmo | input | 1 | Auto-baud timed out |
| id_rd | input | 1 | Strobe: identification word read |
| irq | output | 1 | Interrupt request |
| id_word | output | 10 | Identification word |

## Verification
The clear-on-read of the transmit-empty cause can land in the same cycle as a new line error, and the counter restart can land in the same cycle as a character tick. The bench holds transmit-empty pending, then raises a framing error together with a read strobe. It expects code 011 in that cycle and code 001 still pending once the error is gone. In a second case it drives a push together with a tick and expects the timeout only after four further clean ticks.

// File: rtl/uirq_pkg.sv
`timescale 1ns/1ps
package uirq_pkg;
   typedef enum logic [2:0] {
      CAUSE_NONE = 3'b000,
      CAUSE_THRE = 3'b001,
      CAUSE_RDA  = 3'b010,
      CAUSE_RLS  = 3'b011,
      CAUSE_CTI  = 3'b110
   } cause_e;

   localparam int IEN_W   = 5;
   localparam int ID_W    = 10;
   localparam int EN_RDA  = 0;
   localparam int EN_THRE = 1;
   localparam int EN_RLS  = 2;
   localparam int EN_ABTO = 3;
   localparam int EN_ABEO = 4;
endpackage

// File: rtl/uirq_trig.sv
`timescale 1ns/1ps
module uirq_trig #(
   parameter int FIFO_DEPTH = 16,
   parameter int LVL_W      = $clog2(FIFO_DEPTH + 1),
   parameter int TRIG0      = 1,
   parameter int TRIG1      = 4,
   parameter int TRIG2      = 8,
   parameter int TRIG3      = 14
) (
   input  logic             fifo_on,
   input  logic [1:0]       sel,
   input  logic [LVL_W-1:0] level,
   output logic             at_trig
);
   logic [LVL_W-1:0] thresh;

   initial begin
      assert (TRIG0 >= 1 && TRIG0 <= TRIG1 && TRIG1 <= TRIG2 &&
              TRIG2 <= TRIG3 && TRIG3 <= FIFO_DEPTH)
         else $error("uirq_trig: trigger levels out of order or beyond FIFO depth");
   end

   always_comb begin
      if (!fifo_on) thresh = LVL_W'(1);
      else begin
         unique case (sel)
            2'b00:   thresh = LVL_W'(TRIG0);
            2'b01:   thresh = LVL_W'(TRIG1);
            2'b10:   thresh = LVL_W'(TRIG2);
            default: thresh = LVL_W'(TRIG3);
         endcase
      end
   end

   assign at_trig = (level >= thresh);
endmodule

// File: rtl/uirq_tmo.sv
`timescale 1ns/1ps
module uirq_tmo #(
   parameter int TMO_CHARS = 4,
   parameter int LVL_W     = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_on,
   input  logic [LVL_W-1:0] level,
   input  logic             push,
   input  logic             pop,
   input  logic             tick,
   output logic             hit
);
   localparam int CW = $clog2(TMO_CHARS + 1);

   logic [CW-1:0] cnt;
   logic          act;

   initial begin
      assert (TMO_CHARS >= 1) else $error("uirq_tmo: TMO_CHARS must be at least 1");
   end

   assign act = fifo_on && (level != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         hit <= 1'b0;
      end else if (!act || push || pop) begin
         cnt <= '0;
         hit <= 1'b0;
      end else if (tick && !hit) begin
         cnt <= cnt + 1'b1;
         if (cnt == CW'(TMO_CHARS - 1)) hit <= 1'b1;
      end
   end

   AST_TMO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (push || pop) |=> !hit); // R5
   AST_TMO_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hit) |-> $past(act) && $past(tick)); // R5
endmodule

// File: rtl/uirq_thre.sv
`timescale 1ns/1ps
module uirq_thre (
   input  logic clk,
   input  logic rst_n,
   input  logic thr_empty,
   input  logic clr,
   output logic pend
);
   logic thr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_q <= 1'b0;
         pend  <= 1'b0;
      end else begin
         thr_q <= thr_empty;
         if (!thr_empty)          pend <= 1'b0;
         else if (!thr_q)         pend <= 1'b1;
         else if (clr)            pend <= 1'b0;
      end
   end

   AST_THRE_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_empty && !thr_q) |=> pend); // R6
   AST_THRE_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && thr_q) |=> !pend); // R7
endmodule

// File: rtl/uirq_prio.sv
`timescale 1ns/1ps
module uirq_prio
   import uirq_pkg::*;
#(
   parameter bit HAS_AUTOBAUD = 1'b1
) (
   input  logic   rls,
   input  logic   rda,
   input  logic   cti,
   input  logic   thre,
   input  logic   abe,
   input  logic   abt,
   output cause_e code,
   output logic   pend_n,
   output logic   abe_o,
   output logic   abt_o
);
   logic main_any;

   always_comb begin
      if (rls)       code = CAUSE_RLS;
      else if (rda)  code = CAUSE_RDA;
      else if (cti)  code = CAUSE_CTI;
      else if (thre) code = CAUSE_THRE;
      else           code = CAUSE_NONE;
   end

   assign main_any = rls | rda | cti | thre;

   generate
      if (HAS_AUTOBAUD) begin : g_ab
         assign abe_o  = abe;
         assign abt_o  = abt;
         assign pend_n = !(main_any | abe | abt);
      end else begin : g_no_ab
         assign abe_o  = 1'b0;
         assign abt_o  = 1'b0;
         assign pend_n = !main_any;
      end
   endgenerate
endmodule

// File: rtl/uirq_ident.sv
`timescale 1ns/1ps
module uirq_ident
   import uirq_pkg::*;
#(
   parameter int FIFO_DEPTH   = 16,
   parameter int LVL_W        = $clog2(FIFO_DEPTH + 1),
   parameter int TMO_CHARS    = 4,
   parameter int TRIG0        = 1,
   parameter int TRIG1        = 4,
   parameter int TRIG2        = 8,
   parameter int TRIG3        = 14,
   parameter bit HAS_AUTOBAUD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [4:0]       ien,
   input  logic             fifo_on,
   input  logic [1:0]       trig_sel,
   input  logic [LVL_W-1:0] rx_level,
   input  logic             rx_push,
   input  logic             rx_pop,
   input  logic             char_tick,
   input  logic             err_overrun,
   input  logic             err_parity,
   input  logic             err_frame,
   input  logic             err_break,
   input  logic             thr_empty,
   input  logic             ab_end,
   input  logic             ab_tmo,
   input  logic             id_rd,
   output logic             irq,
   output logic [9:0]       id_word
);
   logic   at_trig, tmo_hit, thre_pend, thre_clr;
   logic   rls_v, rda_v, cti_v, thre_v, abe_v, abt_v;
   logic   pend_n, abe_o, abt_o;
   cause_e code;

   initial begin
      assert (LVL_W >= $clog2(FIFO_DEPTH + 1)) else $error("uirq_ident: LVL_W too narrow");
      assert (IEN_W == 5 && ID_W == 10) else $error("uirq_ident: package widths changed");
   end

   uirq_trig #(
      .FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W),
      .TRIG0(TRIG0), .TRIG1(TRIG1), .TRIG2(TRIG2), .TRIG3(TRIG3)
   ) trig_i (
      .fifo_on(fifo_on), .sel(trig_sel), .level(rx_level), .at_trig(at_trig)
   );

   uirq_tmo #(.TMO_CHARS(TMO_CHARS), .LVL_W(LVL_W)) tmo_i (
      .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on), .level(rx_level),
      .push(rx_push), .pop(rx_pop), .tick(char_tick), .hit(tmo_hit)
   );

   uirq_thre thre_i (
      .clk(clk), .rst_n(rst_n), .thr_empty(thr_empty), .clr(thre_clr), .pend(thre_pend)
   );

   assign rls_v  = ien[EN_RLS]  && (err_overrun | err_parity | err_frame | err_break);
   assign rda_v  = ien[EN_RDA]  && at_trig;
   assign cti_v  = ien[EN_RDA]  && tmo_hit;
   assign thre_v = ien[EN_THRE] && thre_pend;
   assign abe_v  = ien[EN_ABEO] && ab_end;
   assign abt_v  = ien[EN_ABTO] && ab_tmo;

   uirq_prio #(.HAS_AUTOBAUD(HAS_AUTOBAUD)) prio_i (
      .rls(rls_v), .rda(rda_v), .cti(cti_v), .thre(thre_v), .abe(abe_v), .abt(abt_v),
      .code(code), .pend_n(pend_n), .abe_o(abe_o), .abt_o(abt_o)
   );

   assign thre_clr = id_rd && !pend_n && (code == CAUSE_THRE);
   assign irq      = !pend_n;
   assign id_word  = {abt_o, abe_o, fifo_on, fifo_on, 2'b00, code, pend_n};

   AST_RLS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (ien[2] && (err_overrun || err_parity || err_frame || err_break))
         |-> (id_word[3:1] == 3'b011)); // R3
   AST_QUIET_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (ien == 5'b0) |-> (!irq && id_word[0])); // R9
   AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      id_word[0] |-> (id_word[3:1] == 3'b000)); // R2
   AST_FIFO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (id_word[7:6] == {2{fifo_on}}) && (id_word[5:4] == 2'b00)); // R8
endmodule

// File: tb/uirq_ident_tb.sv
`timescale 1ns/1ps
module uirq_ident_tb_top;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [4:0] ien;
   logic       fifo_on;
   logic [1:0] trig_sel;
   logic [4:0] rx_level;
   logic       rx_push, rx_pop, char_tick;
   logic       err_overrun, err_parity, err_frame, err_break;
   logic       thr_empty, ab_end, ab_tmo, id_rd;
   logic       irq;
   logic [9:0] id_word;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   uirq_ident dut_i (
      .clk(clk), .rst_n(rst_n), .ien(ien), .fifo_on(fifo_on), .trig_sel(trig_sel),
      .rx_level(rx_level), .rx_push(rx_push), .rx_pop(rx_pop), .char_tick(char_tick),
      .err_overrun(err_overrun), .err_parity(err_parity), .err_frame(err_frame),
      .err_break(err_break), .thr_empty(thr_empty), .ab_end(ab_end), .ab_tmo(ab_tmo),
      .id_rd(id_rd), .irq(irq), .id_word(id_word)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic settle();
      #1;
   endtask

   task automatic t_reset();
      settle();
      check("R1 irq after reset", 32'(irq), 32'd0);
      check("R1 id after reset", 32'(id_word), 32'h001);
   endtask

   task automatic t_thre();
      ien = 5'b00010;
      thr_empty = 1'b1;
      step(1);
      check("R6 code after rise", 32'(id_word[3:1]), 32'd1);
      check("R2 pending low", 32'(id_word[0]), 32'd0);
      check("R2 irq high", 32'(irq), 32'd1);
      id_rd = 1'b1;
      step(1);
      id_rd = 1'b0;
      settle();
      check("R7 cleared by read", 32'(id_word[0]), 32'd1);
      step(2);
      check("R7 stays cleared", 32'(irq), 32'd0);
      thr_empty = 1'b0;
      step(1);
      thr_empty = 1'b1;
      step(1);
      check("R7 re-armed by new rise", 32'(id_word[3:0]), 32'h2);
   endtask

   task automatic t_disabled();
      ien = 5'b00000;
      err_parity = 1'b1; rx_level = 5'd5; ab_end = 1'b1; ab_tmo = 1'b1;
      settle();
      check("R9 irq masked", 32'(irq), 32'd0);
      check("R9 word idle", 32'(id_word), 32'h001);
      err_parity = 1'b0; rx_level = 5'd0; ab_end = 1'b0; ab_tmo = 1'b0;
      settle();
   endtask

   task automatic t_rls();
      ien = 5'b00111;
      fifo_on = 1'b0;
      rx_level = 5'd5;
      for (int i = 0; i < 4; i++) begin
         err_overrun = (i == 0); err_parity = (i == 1);
         err_frame = (i == 2); err_break = (i == 3);
         settle();
         check($sformatf("R3 line status flag %0d", i), 32'(id_word[3:0]), 32'h6);
      end
      err_break = 1'b0;
      settle();
      check("R4 data over tx empty", 32'(id_word[3:1]), 32'd2);
      rx_level = 5'd0;
      settle();
      check("R6 tx empty lowest", 32'(id_word[3:1]), 32'd1);
   endtask

   task automatic t_rda();
      int lv[4] = '{1, 4, 8, 14};
      ien = 5'b00001;
      fifo_on = 1'b1;
      for (int s = 0; s < 4; s++) begin
         trig_sel = 2'(s);
         rx_level = 5'(lv[s] - 1);
         settle();
         check($sformatf("R4 below trigger sel %0d", s), 32'(id_word[3:0]), 32'h1);
         rx_level = 5'(lv[s]);
         settle();
         check($sformatf("R4 at trigger sel %0d", s), 32'(id_word[3:0]), 32'h4);
      end
      fifo_on = 1'b0;
      rx_level = 5'd1;
      settle();
      check("R4 fifo off trigger one", 32'(id_word[3:0]), 32'h4);
      rx_level = 5'd0;
      step(1);
   endtask

   task automatic t_cti();
      ien = 5'b00001;
      fifo_on = 1'b1;
      trig_sel = 2'b10;
      rx_level = 5'd2;
      step(1);
      char_tick = 1'b1;
      step(3);
      check("R5 no timeout after 3 ticks", 32'(id_word[0]), 32'd1);
      rx_push = 1'b1;
      step(1);
      rx_push = 1'b0;
      rx_level = 5'd3;
      step(3);
      check("R5 push with tick restarts", 32'(id_word[0]), 32'd1);
      step(1);
      check("R5 timeout code", 32'(id_word[3:0]), 32'hC);
      rx_level = 5'd8;
      settle();
      check("R5 data wins over timeout", 32'(id_word[3:1]), 32'd2);
      rx_level = 5'd3;
      char_tick = 1'b0;
      rx_pop = 1'b1;
      step(1);
      rx_pop = 1'b0;
      settle();
      check("R5 pop clears timeout", 32'(id_word[0]), 32'd1);
      rx_level = 5'd0;
      step(1);
   endtask

   task automatic t_collide();
      ien = 5'b00110;
      fifo_on = 1'b0;
      settle();
      check("R6 tx empty pending before collision", 32'(id_word[3:0]), 32'h2);
      err_frame = 1'b1;
      id_rd = 1'b1;
      settle();
      check("R3 error shown during read", 32'(id_word[3:1]), 32'd3);
      step(1);
      id_rd = 1'b0;
      err_frame = 1'b0;
      settle();
      check("R7 read of other code keeps tx empty", 32'(id_word[3:0]), 32'h2);
      id_rd = 1'b1;
      step(1);
      id_rd = 1'b0;
      settle();
      check("R7 read of tx empty clears", 32'(irq), 32'd0);
   endtask

   task automatic t_ab();
      ien = 5'b11000;
      fifo_on = 1'b1;
      ab_end = 1'b1;
      settle();
      check("R8 auto-baud end word", 32'(id_word), 32'h1C0);
      check("R8 auto-baud irq", 32'(irq), 32'd1);
      ab_end = 1'b0;
      ab_tmo = 1'b1;
      settle();
      check("R8 auto-baud timeout word", 32'(id_word), 32'h2C0);
      ien = 5'b10000;
      settle();
      check("R9 auto-baud timeout masked", 32'(id_word), 32'h0C1);
      ab_tmo = 1'b0;
      settle();
   endtask

   initial begin
      rst_n = 1'b0; ien = '0; fifo_on = 1'b0; trig_sel = '0; rx_level = '0;
      rx_push = 1'b0; rx_pop = 1'b0; char_tick = 1'b0;
      err_overrun = 1'b0; err_parity = 1'b0; err_frame = 1'b0; err_break = 1'b0;
      thr_empty = 1'b0; ab_end = 1'b0; ab_tmo = 1'b0; id_rd = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step(1);
      t_reset();
      t_thre();
      t_disabled();
      t_rls();
      t_rda();
      t_cti();
      t_collide();
      t_ab();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1-suite: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule